// File: doc/BRIEF.md
# Dual-Channel Serial ADC Scan Sequencer

This block runs a two-input, 12-bit serial converter over a four-wire SPI link. Every transfer is one 16-bit frame. The control byte is shifted out in the upper half of each frame while the converter shifts back its result. The converter applies a channel selection only to the conversion after the frame that carries it. The sequencer therefore keeps track of which input the next conversion will use. In each frame it sends the command for the channel that is wanted next, and it files every result under the channel that was actually converted.

Scanning is armed by raising a level enable, which also latches the channel mask. Each trigger then runs one scan: a single frame for input 0 alone or input 1 alone, or two back-to-back frames for both inputs. If input 1 is scanned alone, arming first sends a priming frame whose data is thrown away. Dropping the enable sends one restore frame that returns the converter to input 0. While scanning is off, a direct read fetches one sample from either input. Results sit on plain registers with per-channel valid bits and single-cycle strobes; no back-pressure is applied, and each result is held until the next scan or read overwrites it.

Top module: `adc_scan_seq`

## Requirements
- R1: The upper byte of each frame is the control byte and the lower byte is zero. In the control byte, bits 1:0 equal parameter PM_MODE (default 3), bit 3 is the input-1 select and is set only when `dual_en` is 1, bit 4 equals `dual_en`, bit 5 equals `use_ext_ref`, and bits 7:6 and 2 are zero.
- R2: Frame timing:
  - `spi_cs_n` stays low for exactly 16 SCLK rising edges, and MOSI is sent MSB first.
  - MOSI changes only on falling edges, and MISO is sampled on rising edges.
  - One SCLK half period is `clk_div`+1 clocks.
  - SCLK idles at the level of `spi_mode3` (low for mode 0, high for mode 3).
  - Between frames, chip select stays high for at least one SCLK period.
- R3: A sample is the low 12 bits of the 16 bits received, taken unsigned and unshifted; the upper 4 bits are discarded.
- R4: With mask 2'b11 (bit 0 = input 0, bit 1 = input 1), a scan is two frames. The first carries the input-1 command and yields the input-0 sample on `samp0`. The second carries the input-0 command and yields the input-1 sample on `samp1`.
- R5: Arming with mask 2'b10 issues one priming frame carrying the input-1 command, and its data is discarded. Each scan after that is one frame carrying the input-1 command, and it returns the input-1 sample.
- R6: A falling edge on `scan_en` issues exactly one restore frame carrying the input-0 command, after any scan that is still running.
- R7: The mask is latched on the rising edge of `scan_en`. When `dual_en` is 0, mask bit 1 and `rd_ch` are ignored and no input-1 command is ever sent. A mask that is effectively zero is treated as 2'b01.
- R8: `scan_done` is a one-cycle pulse, high in the clock cycle after `spi_cs_n` returns high at the end of a scan's last frame. At that point `samp_vld` equals the effective mask.
- R9: A trigger that arrives while frames are running or pending is dropped, and `scan_overrun` pulses in the next cycle. A trigger that arrives while scanning is not armed has no effect.
- R10: When scanning is off, `rd_req` reads input `rd_ch`. Input 0 takes one input-0 command frame. Input 1 takes a priming frame carrying the input-1 command and then an input-0 command frame. `rd_valid` pulses one cycle after the last frame ends, with `rd_data` holding the sample.
- R11: A `rd_req` made while `scan_en` is high or while frames are running is refused. `rd_busy` pulses in the next cycle and no frame is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | DIV_W | SCLK half period minus one, in clocks |
| spi_mode3 | input | 1 | 1 selects SPI mode 3 (SCLK idles high), 0 selects mode 0 |
| use_ext_ref | input | 1 | External reference in use; sets the reference-disable bit |
| dual_en | input | 1 | Two-input mode; enables input-1 selection |
| scan_en | input | 1 | Scan arm level; edges issue priming and restore frames |
| scan_mask | input | 2 | Channels to scan, bit 0 = input 0, bit 1 = input 1 |
| scan_trig | input | 1 | Starts one scan |
| rd_req | input | 1 | Requests a direct read |
| rd_ch | input | 1 | Channel for the direct read |
| spi_sclk | output | 1 | SPI clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Command data to the converter |
| spi_miso | input | 1 | Result data from the converter |
| samp0 | output | 12 | Last input-0 scan sample |
| samp1 | output | 12 | Last input-1 scan sample |
| samp_vld | output | 2 | Channels captured by the last scan |
| scan_done | output | 1 | One-cycle pulse when a scan completes |
| scan_overrun | output | 1 | One-cycle pulse when a trigger is dropped |
| rd_data | output | 12 | Direct read sample |
| rd_valid | output | 1 | One-cycle pulse when a direct read completes |
| rd_busy | output | 1 | One-cycle pulse when a direct read is refused |

## Verification
Let D = `clk_div`+1, and count from the clock edge that samples a trigger or read request. A one-frame scan or read raises its strobe after 3+32·D further edges. A two-frame operation raises it after 5+66·D further edges. Refusal and overrun strobes appear on the edge after the request. The bench counts clock edges from the request and compares the count with these formulas. It reads results only at falling edges, on the cycle the strobe is seen, and checks one cycle later that the strobe has dropped. Priming and restore frames have no strobe. The bench therefore waits a fixed settling window, longer than one frame plus its gap, and then inspects the frames logged by its converter model.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int FRAME_BITS = 16;
  localparam int SAMPLE_W   = 12;

  typedef enum logic [1:0] {JOB_IDLE, JOB_SCAN, JOB_READ} job_e;
  typedef enum logic [1:0] {FK_DROP, FK_SCAN, FK_READ} frame_kind_e;
  typedef enum logic [1:0] {E_IDLE, E_XFER, E_GAP} eng_state_e;
endpackage

// File: rtl/adc_ctrl_word.sv
module adc_ctrl_word #(
  parameter int PM_MODE = 3
) (
  input  logic        ext_ref,
  input  logic        dual,
  input  logic        sel_ch1,
  output logic [15:0] word
);
  localparam logic [1:0] PM = 2'(PM_MODE);

  always_comb begin
    word        = '0;
    word[15:14] = 2'b00;
    word[13]    = ext_ref;
    word[12]    = dual;
    word[11]    = dual & sel_ch1;
    word[10]    = 1'b0;
    word[9:8]   = PM;
  end
endmodule

// File: rtl/adc_spi_frame.sv
module adc_spi_frame
  import adc_seq_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DIV_W-1:0]      clk_div,
  input  logic                  mode3,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] tx_word,
  output logic                  ready,
  output logic                  fdone,
  output logic [FRAME_BITS-1:0] rx_word,
  output logic                  sclk,
  output logic                  cs_n,
  output logic                  mosi,
  input  logic                  miso
);
  localparam int HALVES = 2 * FRAME_BITS;
  localparam int HW     = $clog2(HALVES);
  localparam logic [HW-1:0] LAST_HALF = HW'(HALVES - 1);

  eng_state_e              st;
  logic [DIV_W-1:0]        cnt;
  logic [HW-1:0]           half;
  logic [FRAME_BITS-1:0]   tx_sh, rx_sh;
  logic                    sclk_i;
  logic                    tick;

  assign tick  = (cnt == clk_div);
  assign ready = (st == E_IDLE);
  assign sclk  = cs_n ? mode3 : sclk_i;
  assign mosi  = cs_n ? 1'b0 : tx_sh[FRAME_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= E_IDLE;
      cnt     <= '0;
      half    <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_word <= '0;
      sclk_i  <= 1'b0;
      cs_n    <= 1'b1;
      fdone   <= 1'b0;
    end else begin
      fdone <= 1'b0;
      case (st)
        E_IDLE: if (start) begin
          st     <= E_XFER;
          cs_n   <= 1'b0;
          cnt    <= '0;
          half   <= '0;
          sclk_i <= 1'b0;
          tx_sh  <= tx_word;
        end
        E_XFER: if (tick) begin
          cnt  <= '0;
          half <= half + 1'b1;
          if (!half[0]) begin
            sclk_i <= 1'b1;
            rx_sh  <= {rx_sh[FRAME_BITS-2:0], miso};
          end else if (half != LAST_HALF) begin
            sclk_i <= 1'b0;
            tx_sh  <= {tx_sh[FRAME_BITS-2:0], 1'b0};
          end
          if (half == LAST_HALF) begin
            st      <= E_GAP;
            cs_n    <= 1'b1;
            fdone   <= 1'b1;
            rx_word <= rx_sh;
            half    <= '0;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
        E_GAP: if (tick) begin
          cnt <= '0;
          if (half[0]) begin
            st   <= E_IDLE;
            half <= '0;
          end else begin
            half <= half + 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (sclk == mode3)); // R2
  AST_MOSI_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && !$fell(sclk_i)) |-> $stable(mosi)); // R2
  AST_START_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !ready) |-> 1'b0); // R2
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dual_en,
  input  logic                  scan_en,
  input  logic [1:0]            scan_mask,
  input  logic                  scan_trig,
  input  logic                  rd_req,
  input  logic                  rd_ch,
  input  logic                  eng_ready,
  input  logic                  fdone,
  input  logic [FRAME_BITS-1:0] rx_word,
  output logic                  start,
  output logic                  fl_cmd,
  output logic [SAMPLE_W-1:0]   samp0,
  output logic [SAMPLE_W-1:0]   samp1,
  output logic [1:0]            samp_vld,
  output logic                  scan_done,
  output logic                  overrun,
  output logic [SAMPLE_W-1:0]   rd_data,
  output logic                  rd_valid,
  output logic                  rd_busy
);
  job_e        job;
  frame_kind_e fl_kind, nx_kind;
  logic        scan_en_q, pend_restore, pend_prime, idx, rd_ch_q, conv_ch;
  logic        waiting, fl_cap, fl_last;
  logic [1:0]  mask_q, eff_mask;
  logic        first_ch, nx_go, nx_cmd, nx_last, issue, busy, arm, disarm;

  assign first_ch = (mask_q == 2'b10);
  assign arm      = scan_en && !scan_en_q;
  assign disarm   = !scan_en && scan_en_q;
  assign busy     = (job != JOB_IDLE) || pend_restore || pend_prime || waiting;
  assign issue    = nx_go && !waiting && eng_ready;

  always_comb begin
    eff_mask = dual_en ? scan_mask : {1'b0, scan_mask[0]};
    if (eff_mask == 2'b00) eff_mask = 2'b01;
  end

  always_comb begin
    nx_go   = 1'b1;
    nx_cmd  = 1'b0;
    nx_kind = FK_DROP;
    nx_last = 1'b0;
    if (job == JOB_SCAN) begin
      nx_kind = FK_SCAN;
      if (mask_q == 2'b11) begin
        nx_cmd  = ~idx;
        nx_last = idx;
      end else begin
        nx_cmd  = first_ch;
        nx_last = 1'b1;
      end
    end else if (job == JOB_READ) begin
      if (conv_ch != rd_ch_q) begin
        nx_cmd = rd_ch_q;
      end else begin
        nx_kind = FK_READ;
        nx_last = 1'b1;
      end
    end else if (pend_restore) begin
      nx_cmd = 1'b0;
    end else if (pend_prime) begin
      nx_cmd = first_ch;
    end else begin
      nx_go = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      job <= JOB_IDLE;   fl_kind <= FK_DROP;
      scan_en_q <= 1'b0; pend_restore <= 1'b0; pend_prime <= 1'b0;
      idx <= 1'b0;       rd_ch_q <= 1'b0;      conv_ch <= 1'b0;
      waiting <= 1'b0;   fl_cap <= 1'b0;       fl_last <= 1'b0;
      fl_cmd <= 1'b0;    mask_q <= 2'b01;      start <= 1'b0;
      samp0 <= '0;       samp1 <= '0;          samp_vld <= '0;
      scan_done <= 1'b0; overrun <= 1'b0;      rd_data <= '0;
      rd_valid <= 1'b0;  rd_busy <= 1'b0;
    end else begin
      scan_en_q <= scan_en;
      start     <= 1'b0;
      scan_done <= 1'b0;
      overrun   <= 1'b0;
      rd_valid  <= 1'b0;
      rd_busy   <= 1'b0;

      if (issue) begin
        start   <= 1'b1;
        waiting <= 1'b1;
        fl_cmd  <= nx_cmd;
        fl_kind <= nx_kind;
        fl_cap  <= conv_ch;
        fl_last <= nx_last;
        if (job == JOB_IDLE) begin
          if (pend_restore) pend_restore <= 1'b0;
          else              pend_prime   <= 1'b0;
        end
      end

      if (fdone && waiting) begin
        waiting <= 1'b0;
        conv_ch <= fl_cmd;
        if (fl_kind == FK_SCAN) begin
          if (fl_cap) begin
            samp1       <= rx_word[SAMPLE_W-1:0];
            samp_vld[1] <= 1'b1;
          end else begin
            samp0       <= rx_word[SAMPLE_W-1:0];
            samp_vld[0] <= 1'b1;
          end
          if (fl_last) begin
            job       <= JOB_IDLE;
            scan_done <= 1'b1;
          end else begin
            idx <= 1'b1;
          end
        end else if (fl_kind == FK_READ) begin
          rd_data  <= rx_word[SAMPLE_W-1:0];
          rd_valid <= 1'b1;
          job      <= JOB_IDLE;
        end
      end

      if (arm) begin
        mask_q     <= eff_mask;
        pend_prime <= (eff_mask == 2'b10);
      end
      if (disarm) begin
        pend_restore <= 1'b1;
        pend_prime   <= 1'b0;
      end

      if (scan_trig && scan_en && scan_en_q) begin
        if (busy) begin
          overrun <= 1'b1;
        end else begin
          job      <= JOB_SCAN;
          idx      <= 1'b0;
          samp_vld <= 2'b00;
        end
      end

      if (rd_req) begin
        if (scan_en || busy) begin
          rd_busy <= 1'b1;
        end else begin
          job     <= JOB_READ;
          rd_ch_q <= rd_ch & dual_en;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> !scan_done); // R8
  AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(scan_trig)); // R9
  AST_RD_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_busy |-> ($past(rd_req) && !rd_valid)); // R11
  AST_NO_CH1_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_done && !dual_en) |-> !samp_vld[1]); // R7
  AST_RESTORE_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scan_en) |=> (pend_restore || (start && !fl_cmd))); // R6
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int PM_MODE = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DIV_W-1:0]    clk_div,
  input  logic                spi_mode3,
  input  logic                use_ext_ref,
  input  logic                dual_en,
  input  logic                scan_en,
  input  logic [1:0]          scan_mask,
  input  logic                scan_trig,
  input  logic                rd_req,
  input  logic                rd_ch,
  output logic                spi_sclk,
  output logic                spi_cs_n,
  output logic                spi_mosi,
  input  logic                spi_miso,
  output logic [SAMPLE_W-1:0] samp0,
  output logic [SAMPLE_W-1:0] samp1,
  output logic [1:0]          samp_vld,
  output logic                scan_done,
  output logic                scan_overrun,
  output logic [SAMPLE_W-1:0] rd_data,
  output logic                rd_valid,
  output logic                rd_busy
);
  logic                  start, fl_cmd, eng_ready, fdone;
  logic [FRAME_BITS-1:0] tx_word, rx_word;

  adc_ctrl_word #(.PM_MODE(PM_MODE)) u_word (
    .ext_ref(use_ext_ref), .dual(dual_en), .sel_ch1(fl_cmd), .word(tx_word)
  );

  adc_spi_frame #(.DIV_W(DIV_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .mode3(spi_mode3),
    .start(start), .tx_word(tx_word), .ready(eng_ready), .fdone(fdone),
    .rx_word(rx_word), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .miso(spi_miso)
  );

  adc_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .dual_en(dual_en), .scan_en(scan_en),
    .scan_mask(scan_mask), .scan_trig(scan_trig), .rd_req(rd_req),
    .rd_ch(rd_ch), .eng_ready(eng_ready), .fdone(fdone), .rx_word(rx_word),
    .start(start), .fl_cmd(fl_cmd), .samp0(samp0), .samp1(samp1),
    .samp_vld(samp_vld), .scan_done(scan_done), .overrun(scan_overrun),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_busy(rd_busy)
  );

  AST_DONE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_done || rd_valid) |-> (spi_cs_n && $past(spi_cs_n))); // R8
endmodule

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;
  localparam int DIVW = 8;
  localparam int D    = 2;
  localparam int ONE_FRAME = 4 + 32 * D;
  localparam int TWO_FRAME = 6 + 66 * D;
  localparam int SETTLE    = 40 * D + 40;

  // dual, ext_ref, mode3, mask[1:0], v0[11:0], v1[11:0]
  localparam logic [28:0] VEC [5] = '{
    {1'b1, 1'b0, 1'b0, 2'b11, 12'h123, 12'hABC},
    {1'b1, 1'b1, 1'b1, 2'b10, 12'h456, 12'h7FF},
    {1'b1, 1'b0, 1'b1, 2'b01, 12'hFFF, 12'h001},
    {1'b0, 1'b1, 1'b0, 2'b11, 12'h800, 12'h555},
    {1'b1, 1'b1, 1'b0, 2'b00, 12'h0A5, 12'h5A0}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, spi_mode3, use_ext_ref, dual_en, scan_en, scan_trig, rd_req, rd_ch;
  logic [1:0] scan_mask;
  logic spi_sclk, spi_cs_n, spi_mosi, spi_miso;
  logic [11:0] samp0, samp1, rd_data;
  logic [1:0] samp_vld;
  logic scan_done, scan_overrun, rd_valid, rd_busy;

  adc_scan_seq #(.DIV_W(DIVW)) dut (
    .clk(clk), .rst_n(rst_n), .clk_div(DIVW'(D - 1)), .spi_mode3(spi_mode3),
    .use_ext_ref(use_ext_ref), .dual_en(dual_en), .scan_en(scan_en),
    .scan_mask(scan_mask), .scan_trig(scan_trig), .rd_req(rd_req), .rd_ch(rd_ch),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .samp0(samp0), .samp1(samp1), .samp_vld(samp_vld),
    .scan_done(scan_done), .scan_overrun(scan_overrun), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_busy(rd_busy)
  );

  // converter model: result of a frame is the channel chosen by the previous frame
  logic [11:0] v0 = '0, v1 = '0;
  logic        m_ch = 1'b0, m_in = 1'b0;
  logic [15:0] m_tx = '0, m_rx = '0;
  int          m_bits = 0;
  logic [15:0] log_w [8];
  int          log_b [8];
  int          log_n = 0;
  longint      t_rise = 0, min_gap = 64'd1000000000;

  assign spi_miso = (m_in && m_bits < 16) ? m_tx[15 - m_bits] : 1'b0;

  always @(negedge spi_cs_n) begin
    if (t_rise != 0 && ($time - t_rise) < min_gap) min_gap = $time - t_rise;
    m_in = 1'b1;
    m_bits = 0;
    m_tx = {4'h5, m_ch ? v1 : v0};
  end
  always @(posedge spi_sclk) if (m_in) begin
    m_rx = {m_rx[14:0], spi_mosi};
    m_bits++;
  end
  always @(posedge spi_cs_n) if (m_in) begin
    m_in = 1'b0;
    t_rise = $time;
    if (log_n < 8) begin
      log_w[log_n] = m_rx;
      log_b[log_n] = m_bits;
    end
    log_n++;
    m_ch = m_rx[12] & m_rx[11];
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ctrl_w(input logic ext, input logic dual, input logic ch1);
    return {2'b00, ext, dual, ch1 & dual, 1'b0, 2'b11, 8'h00};
  endfunction

  // counts edges from the sampling edge until the strobe is seen at a falling edge
  task automatic wait_strobe(input bit rd, output int n);
    n = 1;
    while (!(rd ? rd_valid : scan_done) && n < 3000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
  endtask

  task automatic trig_pulse();
    @(negedge clk) scan_trig = 1'b1;
    @(negedge clk) scan_trig = 1'b0;
  endtask

  task automatic rd_pulse(input logic ch);
    @(negedge clk) begin rd_req = 1'b1; rd_ch = ch; end
    @(negedge clk) rd_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    logic dl, ex, m3;
    logic [1:0] mk, em;
    rst_n = 1'b0; spi_mode3 = 1'b0; use_ext_ref = 1'b0; dual_en = 1'b0;
    scan_en = 1'b0; scan_mask = 2'b01; scan_trig = 1'b0; rd_req = 1'b0; rd_ch = 1'b0;
    repeat (4) @(negedge clk);
    check("R2", "reset cs_n", spi_cs_n, 1);
    check("R2", "reset sclk idle", spi_sclk, 0);
    check("R8", "reset valid", samp_vld, 0);
    check("R8", "reset done", scan_done, 0);
    check("R10", "reset rd_valid", rd_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < 5; i++) begin
      {dl, ex, m3, mk, v0, v1} = VEC[i];
      dual_en = dl; use_ext_ref = ex; spi_mode3 = m3; scan_mask = mk;
      em = dl ? mk : {1'b0, mk[0]};
      if (em == 2'b00) em = 2'b01;
      repeat (5) @(negedge clk);
      check("R2", "idle sclk level", spi_sclk, m3);
      log_n = 0;
      scan_en = 1'b1;
      repeat (SETTLE) @(negedge clk);
      check("R5", "priming frame count", log_n, (em == 2'b10) ? 1 : 0);
      if (em == 2'b10) check("R5", "priming command", log_w[0], ctrl_w(ex, dl, 1'b1));
      log_n = 0;
      trig_pulse();
      wait_strobe(1'b0, n);
      check("R8", "scan latency", n, (em == 2'b11) ? TWO_FRAME : ONE_FRAME);
      check("R7", "valid bits", samp_vld, em);
      if (em[0]) check("R3", "input-0 sample", samp0, v0);
      if (em[1]) check("R4", "input-1 sample", samp1, v1);
      check("R4", "scan frame count", log_n, (em == 2'b11) ? 2 : 1);
      check("R1", "first scan command", log_w[0], ctrl_w(ex, dl, em[1]));
      check("R2", "bits per frame", log_b[0], 16);
      if (em == 2'b11) check("R4", "second scan command", log_w[1], ctrl_w(ex, dl, 1'b0));
      @(negedge clk);
      check("R8", "done one cycle", scan_done, 0);
      log_n = 0;
      scan_en = 1'b0;
      repeat (SETTLE) @(negedge clk);
      check("R6", "restore frame count", log_n, 1);
      check("R6", "restore command", log_w[0], ctrl_w(ex, dl, 1'b0));
    end
    check("R2", "chip-select gap >= one SCLK period", min_gap >= 2 * D * 10, 1);

    // overrun during a two-frame scan
    dual_en = 1'b1; use_ext_ref = 1'b0; spi_mode3 = 1'b0; scan_mask = 2'b11;
    v0 = 12'h321; v1 = 12'h654;
    scan_en = 1'b1;
    repeat (20) @(negedge clk);
    log_n = 0;
    trig_pulse();
    repeat (5) @(negedge clk);
    scan_trig = 1'b1;
    @(negedge clk) scan_trig = 1'b0;
    check("R9", "overrun pulse", scan_overrun, 1);
    @(negedge clk);
    check("R9", "overrun one cycle", scan_overrun, 0);
    wait_strobe(1'b0, n);
    check("R9", "sample after overrun", samp1, 12'h654);
    repeat (SETTLE) @(negedge clk);
    check("R9", "frames after dropped trigger", log_n, 2);

    // refused direct read while armed
    log_n = 0;
    rd_pulse(1'b0);
    check("R11", "rd_busy pulse", rd_busy, 1);
    repeat (SETTLE) @(negedge clk);
    check("R11", "no frame on refused read", log_n, 0);

    scan_en = 1'b0;
    repeat (SETTLE) @(negedge clk);
    log_n = 0;
    trig_pulse();
    repeat (SETTLE) @(negedge clk);
    check("R9", "unarmed trigger frames", log_n, 0);

    // direct reads
    rd_pulse(1'b0);
    wait_strobe(1'b1, n);
    check("R10", "read input-0 latency", n, ONE_FRAME);
    check("R10", "read input-0 data", rd_data, 12'h321);
    check("R10", "read input-0 frames", log_n, 1);
    repeat (SETTLE) @(negedge clk);
    log_n = 0;
    rd_pulse(1'b1);
    wait_strobe(1'b1, n);
    check("R10", "read input-1 latency", n, TWO_FRAME);
    check("R10", "read input-1 data", rd_data, 12'h654);
    check("R10", "read input-1 prime", log_w[0], ctrl_w(1'b0, 1'b1, 1'b1));
    check("R10", "read input-1 restore", log_w[1], ctrl_w(1'b0, 1'b1, 1'b0));
    repeat (SETTLE) @(negedge clk);
    dual_en = 1'b0;
    log_n = 0;
    rd_pulse(1'b1);
    wait_strobe(1'b1, n);
    check("R7", "single mode read channel", rd_data, 12'h321);
    check("R7", "single mode read frames", log_n, 1);
    check("R7", "single mode read command", log_w[0], ctrl_w(1'b0, 1'b0, 1'b0));

    repeat (10) @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule